// File: doc/BRIEF.md
# Gshare Branch Direction Predictor with Speculative History

This block predicts the direction of conditional branches, one prediction per clock. It keeps a table of two-bit saturating counters. The table is indexed by the branch address XORed with a global history of recent branch directions. The prediction is combinational: the front end presents a branch address, and the same cycle it gets a taken or not-taken answer. It also gets a snapshot of the history that produced that answer.

The history does not wait for branches to resolve. When a prediction is accepted, the predicted direction is shifted into the history at once, so back-to-back predictions each see the outcomes assumed for the branches before them. The snapshot travels down the pipeline with the branch. When the branch retires, the resolve port returns the address, the snapshot and the real direction. The counter at the snapshot's index is trained. If the branch was mispredicted, the history is rebuilt from the snapshot plus the real direction. A separate flush loads any saved snapshot, for example on an exception.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history is all zeros. Every counter holds the weakly not-taken value 1, so every address predicts not-taken.
- R2: Forming the table index and reading the prediction:
  - The history is folded into the index width: history bit i is XORed into index bit (i mod TABLE_BITS).
  - The index is address bits [PC_LSB +: TABLE_BITS] XORed with the folded history.
  - `pred_taken_o` is 1 in the same cycle when the indexed counter is 2 or 3.
- R3: `pred_hist_o` always shows the history that the current prediction was made with.
- R4: In a cycle with `pred_valid_i` high and no flush or repair, the next history is the old history shifted left by one bit, with `pred_taken_o` entering at bit 0.
- R5: With no prediction, repair or flush in a cycle, the history keeps its value.
- R6: On `res_valid_i`, the indexed counter changes by one step:
  - It goes up by one when `res_taken_i` is 1.
  - It goes down by one when `res_taken_i` is 0.
- R7: Training uses the index formed from `res_pc_i` and the returned snapshot `res_hist_i`, never from the current history.
- R8: When `res_valid_i` and `res_mispredict_i` are both high, the next history is `res_hist_i` shifted left with `res_taken_i` entering at bit 0. This overrides a speculative shift in the same cycle.
- R9: `flush_i` loads `flush_hist_i` into the history. It overrides both repair and speculative shift.
- R10: If a prediction and a training update hit the same counter in one cycle, the prediction shows the value before training. The trained value is seen from the next cycle on.
- R11: Counters saturate: taken at 3 leaves 3, and not-taken at 0 leaves 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid_i | input | 1 | A prediction is consumed this cycle; shift history |
| pred_pc_i | input | PC_W | Address of the branch being predicted |
| pred_taken_o | output | 1 | Predicted direction (1 = taken) |
| pred_hist_o | output | HIST_W | History snapshot used for this prediction |
| res_valid_i | input | 1 | A branch resolves this cycle; train its counter |
| res_pc_i | input | PC_W | Address of the resolving branch |
| res_hist_i | input | HIST_W | Snapshot carried by the resolving branch |
| res_taken_i | input | 1 | Actual direction of the resolving branch |
| res_mispredict_i | input | 1 | The resolving branch was mispredicted; repair history |
| flush_i | input | 1 | Load history from `flush_hist_i` |
| flush_hist_i | input | HIST_W | History value to load on flush |

## Verification
Two functions can land in the same cycle.

The first pair is a prediction and a retirement update. They may read and write the same counter. The bench provokes this by steering a prediction onto the counter being trained, then checks that the answer comes from the old counter and that the next cycle shows the new one.

The second pair is a speculative shift and a history repair or flush. The bench drives these together in directed cycles and in a long random stream. A reference model with the priority flush, then repair, then shift decides which history must appear one cycle later.

// File: rtl/gshare_pkg.sv
// Package: shared counter type and helpers for the gshare predictor.
// Assumes two-bit counters where the upper bit is the predicted direction.
package gshare_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'd0;
    localparam ctr_t CTR_WEAK_NT   = 2'd1;
    localparam ctr_t CTR_WEAK_T    = 2'd2;
    localparam ctr_t CTR_STRONG_T  = 2'd3;

    // Saturating one-step move of a counter toward the observed direction.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? CTR_STRONG_T : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? CTR_STRONG_NT : cur - 2'd1;
        end
        return nxt;
    endfunction

    // Direction implied by a counter value: taken when value is 2 or 3.
    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gshare_index.sv
// Module: gshare_index
// Combinational hash of a branch address and a history into a table index.
// History bit i is folded onto index bit (i mod TABLE_BITS), then XORed
// with the address slice starting at PC_LSB.
// Assumes PC_LSB + TABLE_BITS <= PC_W.
module gshare_index #(
    parameter int PC_W       = 32,
    parameter int PC_LSB     = 2,
    parameter int HIST_W     = 10,
    parameter int TABLE_BITS = 10
) (
    input  logic [PC_W-1:0]       pc_i,
    input  logic [HIST_W-1:0]     hist_i,
    output logic [TABLE_BITS-1:0] idx_o
);

    logic [TABLE_BITS-1:0] folded;
    logic [TABLE_BITS-1:0] pc_slice;

    assign pc_slice = pc_i[PC_LSB +: TABLE_BITS];

    generate
        if (HIST_W == TABLE_BITS) begin : g_direct
            // Widths match: the history is used bit for bit.
            always_comb folded = hist_i;
        end else if (HIST_W < TABLE_BITS) begin : g_zext
            // Shorter history: zero-extend into the upper index bits.
            always_comb folded = {{(TABLE_BITS-HIST_W){1'b0}}, hist_i};
        end else begin : g_fold
            // Longer history: XOR-fold every bit onto index bit (i mod TABLE_BITS).
            always_comb begin
                folded = '0;
                for (int i = 0; i < HIST_W; i++) begin
                    folded[i % TABLE_BITS] = folded[i % TABLE_BITS] ^ hist_i[i];
                end
            end
        end
    endgenerate

    assign idx_o = pc_slice ^ folded;

endmodule

// File: rtl/gshare_counter_table.sv
// Module: gshare_counter_table
// Table of 2**TABLE_BITS two-bit saturating counters.
// One combinational read port and one synchronous training port.
// A read and a write to the same entry in one cycle return the old value.
// Assumes a synchronous active-low reset that sets all entries to weakly not-taken.
module gshare_counter_table
    import gshare_pkg::*;
#(
    parameter int TABLE_BITS = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TABLE_BITS-1:0] rd_idx_i,
    output ctr_t                  rd_ctr_o,
    input  logic                  wr_en_i,
    input  logic [TABLE_BITS-1:0] wr_idx_i,
    input  logic                  wr_taken_i
);

    localparam int ENTRIES = 1 << TABLE_BITS;

    ctr_t mem [ENTRIES];

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            logic hit;
            assign hit = wr_en_i && (wr_idx_i == TABLE_BITS'(e));

            // Per-entry counter: reset to weak not-taken, step when trained.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[e] <= CTR_WEAK_NT;
                end else if (hit) begin
                    mem[e] <= ctr_step(mem[e], wr_taken_i);
                end
            end
        end
    endgenerate

    assign rd_ctr_o = mem[rd_idx_i];

endmodule

// File: rtl/gshare_history.sv
// Module: gshare_history
// Global history register.
// Update priority: flush load, then mispredict repair, then speculative shift.
// The newest direction enters at bit 0 and older bits move up.
// Assumes HIST_W >= 2.
module gshare_history #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [HIST_W-1:0] flush_hist_i,
    input  logic              repair_i,
    input  logic [HIST_W-1:0] repair_hist_i,
    input  logic              repair_taken_i,
    input  logic              spec_i,
    input  logic              spec_taken_i,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    // Choose the next history by the fixed priority.
    always_comb begin
        hist_d = hist_q;
        if (flush_i) begin
            hist_d = flush_hist_i;
        end else if (repair_i) begin
            hist_d = {repair_hist_i[HIST_W-2:0], repair_taken_i};
        end else if (spec_i) begin
            hist_d = {hist_q[HIST_W-2:0], spec_taken_i};
        end
    end

    // Register the history; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/gshare_predictor.sv
// Module: gshare_predictor (top)
// Gshare direction predictor with a speculatively updated global history.
// The predict path is combinational from pred_pc_i and the current history.
// The resolve path trains the counter selected by the returned snapshot.
// On a mispredict it also rebuilds the history.
// Assumes at most one prediction and one resolution per cycle.
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int PC_LSB     = 2,
    parameter int HIST_W     = 10,
    parameter int TABLE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid_i,
    input  logic [PC_W-1:0]   pred_pc_i,
    output logic              pred_taken_o,
    output logic [HIST_W-1:0] pred_hist_o,
    input  logic              res_valid_i,
    input  logic [PC_W-1:0]   res_pc_i,
    input  logic [HIST_W-1:0] res_hist_i,
    input  logic              res_taken_i,
    input  logic              res_mispredict_i,
    input  logic              flush_i,
    input  logic [HIST_W-1:0] flush_hist_i
);

    logic [HIST_W-1:0]     cur_hist;
    logic [TABLE_BITS-1:0] pred_idx;
    logic [TABLE_BITS-1:0] train_idx;
    ctr_t                  pred_ctr;
    logic                  repair_req;

    // Prediction index from the live history.
    gshare_index #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_W(HIST_W), .TABLE_BITS(TABLE_BITS)
    ) u_pred_index (
        .pc_i   (pred_pc_i),
        .hist_i (cur_hist),
        .idx_o  (pred_idx)
    );

    // Training index from the snapshot carried by the resolving branch.
    gshare_index #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_W(HIST_W), .TABLE_BITS(TABLE_BITS)
    ) u_train_index (
        .pc_i   (res_pc_i),
        .hist_i (res_hist_i),
        .idx_o  (train_idx)
    );

    gshare_counter_table #(
        .TABLE_BITS(TABLE_BITS)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (pred_idx),
        .rd_ctr_o   (pred_ctr),
        .wr_en_i    (res_valid_i),
        .wr_idx_i   (train_idx),
        .wr_taken_i (res_taken_i)
    );

    assign repair_req = res_valid_i && res_mispredict_i;

    gshare_history #(
        .HIST_W(HIST_W)
    ) u_history (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_i        (flush_i),
        .flush_hist_i   (flush_hist_i),
        .repair_i       (repair_req),
        .repair_hist_i  (res_hist_i),
        .repair_taken_i (res_taken_i),
        .spec_i         (pred_valid_i),
        .spec_taken_i   (pred_taken_o),
        .hist_o         (cur_hist)
    );

    assign pred_taken_o = ctr_says_taken(pred_ctr);
    assign pred_hist_o  = cur_hist;

endmodule

// File: rtl/gshare_predictor_checker.sv
// Module: gshare_predictor_checker
// Port-level properties of the history register, bound into gshare_predictor.
module gshare_predictor_checker #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_valid_i,
    input logic [PC_W-1:0]   pred_pc_i,
    input logic              pred_taken_o,
    input logic [HIST_W-1:0] pred_hist_o,
    input logic              res_valid_i,
    input logic              res_taken_i,
    input logic              res_mispredict_i,
    input logic [HIST_W-1:0] res_hist_i,
    input logic              flush_i,
    input logic [HIST_W-1:0] flush_hist_i
);

    logic [HIST_W-1:0] repaired;
    logic [HIST_W-1:0] shifted;
    logic              repair;

    assign repaired = {res_hist_i[HIST_W-2:0], res_taken_i};
    assign shifted  = {pred_hist_o[HIST_W-2:0], pred_taken_o};
    assign repair   = res_valid_i && res_mispredict_i;

    // R1: reset clears the history.
    assert_reset_hist_R1: assert property (@(posedge clk)
        !rst_n |=> pred_hist_o == '0);

    // R9: flush loads the supplied history.
    assert_flush_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> pred_hist_o == $past(flush_hist_i));

    // R8: repair rebuilds from the snapshot and the real direction.
    assert_repair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (repair && !flush_i) |=> pred_hist_o == $past(repaired));

    // R4: speculative shift uses the predicted direction.
    assert_spec_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_i && !repair && !flush_i) |=> pred_hist_o == $past(shifted));

    // R5: idle cycles keep the history.
    assert_hist_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid_i && !repair && !flush_i) |=> $stable(pred_hist_o));

    // R2: the prediction is always a known value.
    assert_pred_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_taken_o));

endmodule

bind gshare_predictor gshare_predictor_checker #(
    .PC_W(PC_W), .HIST_W(HIST_W)
) u_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .pred_valid_i     (pred_valid_i),
    .pred_pc_i        (pred_pc_i),
    .pred_taken_o     (pred_taken_o),
    .pred_hist_o      (pred_hist_o),
    .res_valid_i      (res_valid_i),
    .res_taken_i      (res_taken_i),
    .res_mispredict_i (res_mispredict_i),
    .res_hist_i       (res_hist_i),
    .flush_i          (flush_i),
    .flush_hist_i     (flush_hist_i)
);

// File: tb/gshare_predictor_bench.sv
// Bench: small configuration (4-bit history, 16 counters, 8-bit address)
// against an arithmetic reference model.
module gshare_predictor_bench;

    localparam int PC_W = 8;
    localparam int PC_LSB = 2;
    localparam int HW = 4;
    localparam int TB = 4;
    localparam int N = 1 << TB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pred_valid = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic pred_taken;
    logic [HW-1:0] pred_hist;
    logic res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic [HW-1:0] res_hist = '0;
    logic res_taken = 1'b0;
    logic res_mis = 1'b0;
    logic flush = 1'b0;
    logic [HW-1:0] flush_hist = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int cnt_m [N];
    int hist_m;
    string hist_tag;

    always #4 clk = ~clk;

    gshare_predictor #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_W(HW), .TABLE_BITS(TB)
    ) u_gshare_predictor (
        .clk(clk), .rst_n(rst_n),
        .pred_valid_i(pred_valid), .pred_pc_i(pred_pc),
        .pred_taken_o(pred_taken), .pred_hist_o(pred_hist),
        .res_valid_i(res_valid), .res_pc_i(res_pc), .res_hist_i(res_hist),
        .res_taken_i(res_taken), .res_mispredict_i(res_mis),
        .flush_i(flush), .flush_hist_i(flush_hist)
    );

    function automatic int idx_of(input int pc, input int h);
        return ((pc >> PC_LSB) & (N - 1)) ^ h;
    endfunction

    function automatic int shl(input int h, input int b);
        return ((h << 1) | b) & ((1 << HW) - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Check outputs for current inputs, advance the model, step one cycle.
    task automatic step(input string ptag);
        int e;
        int p;
        int r;
        #1;
        e = (cnt_m[idx_of(pred_pc, hist_m)] >= 2) ? 1 : 0;
        check(pred_taken == e[0], ptag, "pred_taken", pred_taken, e);
        check(pred_hist == HW'(hist_m), hist_tag, "pred_hist", pred_hist, hist_m);
        p = e;
        if (res_valid) begin
            r = idx_of(res_pc, res_hist);
            if (res_taken) cnt_m[r] = (cnt_m[r] == 3) ? 3 : cnt_m[r] + 1;
            else           cnt_m[r] = (cnt_m[r] == 0) ? 0 : cnt_m[r] - 1;
        end
        if (flush) begin
            hist_m = flush_hist; hist_tag = "R9";
        end else if (res_valid && res_mis) begin
            hist_m = shl(res_hist, res_taken); hist_tag = "R8";
        end else if (pred_valid) begin
            hist_m = shl(hist_m, p); hist_tag = "R4";
        end else begin
            hist_tag = "R5";
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        pred_valid = 0; res_valid = 0; res_mis = 0; flush = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) cnt_m[i] = 1;
        hist_m = 0;
        hist_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every entry predicts not-taken with zero history; no shift.
        for (int a = 0; a < N; a++) begin
            pred_pc = PC_W'(a << PC_LSB);
            step("R1");
        end

        // R10: train entry 3 while predicting it; old value first, new after.
        pred_pc = PC_W'(3 << PC_LSB);
        res_valid = 1; res_pc = pred_pc; res_hist = 0; res_taken = 1;
        step("R10");
        res_valid = 0;
        step("R10");
        res_valid = 1; res_taken = 0;
        step("R10");
        res_valid = 0;
        step("R10");

        // R6 / R11: walk every counter up past saturation and down past zero.
        for (int a = 0; a < N; a++) begin
            pred_pc = PC_W'(a << PC_LSB);
            res_pc = pred_pc; res_hist = 0;
            for (int k = 0; k < 10; k++) begin
                res_valid = 1; res_taken = (k < 5);
                step((k == 4 || k == 9) ? "R11" : "R6");
            end
            res_valid = 0;
            step("R11");
        end

        // R7: history is 5; training with snapshot 0 must hit index a, not a^5.
        flush = 1; flush_hist = 4'd5;
        step("R9");
        idle_inputs();
        res_pc = PC_W'(6 << PC_LSB); res_hist = 0;
        pred_pc = PC_W'((6 ^ 5) << PC_LSB);
        for (int k = 0; k < 2; k++) begin
            res_valid = 1; res_taken = 1;
            step("R7");
        end
        res_valid = 0;
        step("R7");

        // R8 / R9 over R4: predictions shift until repair or flush wins.
        pred_valid = 1;
        step("R4");
        step("R4");
        res_valid = 1; res_mis = 1; res_hist = 4'b1010; res_taken = 1;
        step("R8");
        flush = 1; flush_hist = 4'b0110;
        step("R9");
        idle_inputs();
        step("R3");
        step("R5");

        // R2 / R3 / R4 / R8: random mixed stream against the model.
        for (int c = 0; c < 4000; c++) begin
            pred_valid = ($urandom_range(0, 9) < 7);
            pred_pc = PC_W'($urandom);
            res_valid = ($urandom_range(0, 9) < 4);
            res_pc = PC_W'($urandom);
            res_hist = HW'($urandom);
            res_taken = $urandom_range(0, 1);
            res_mis = ($urandom_range(0, 9) < 3);
            flush = ($urandom_range(0, 19) == 0);
            flush_hist = HW'($urandom);
            step("R2");
        end
        idle_inputs();
        step("R3");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule